// File: doc/BRIEF.md
# Four-Channel Serial DAC Code Register Front End

This block is the digital input stage of a four-channel, 12-bit DAC. A host writes 16-bit frames over a three-wire serial port (active-low select, serial clock, serial data). Each frame carries a 2-bit channel address, two unused filler bits and a 12-bit code. A level-sensitive, active-low load input then lets the addressed channel register take the 12-bit code from the shift register. The four channel codes leave the block as one packed output that drives the converter cores.

Every pin is sampled by a fast system clock through a two-stage synchronizer, so the whole block is synchronous. The select and serial clock pins are combined by OR into a single effective shift clock, and every rising edge of that combined signal shifts one bit. This includes the edge that appears when select is raised while the serial clock is low. An active-low clear forces all four channel registers to midscale or zero-scale, as chosen by a range-select pin. A one-cycle error pulse marks any shift that happens while load is held low.

Top module: `qdac_front`

## Requirements
- R1: A frame is 16 bits sent first-bit-first. After 16 shifts the first bit sent sits at frame bit 15. Bits [15:14] are the channel address, bits [13:12] are ignored filler and bits [11:0] are the channel code.
- R2: While cs_n is low, each rising edge of sclk shifts the frame left by one place and puts the current sdi value into bit 0.
- R3: A rising edge of cs_n while sclk is low counts as one extra shift edge and takes in one extra sdi bit.
- R4: Address 0 writes channel 0 (ch_code[11:0]), 1 writes channel 1, 2 writes channel 2 and 3 writes channel 3. The other channels keep their values.
- R5: While ld_n is low and clr_n is high, the addressed channel follows the code field of the shift register. When ld_n is high the channel holds its value.
- R6: While clr_n is low, all four channels are set to 0x800 if clsel is 1 and to 0x000 if clsel is 0. ld_n has no effect during this time.
- R7: After clr_n returns high, the channels keep the clear value until ld_n goes low. A load then uses whatever the shift register holds, including a frame shifted in before the clear.
- R8: While cs_n is high, sclk activity does not change the shift register.
- R9: proto_err pulses high when an effective shift edge occurs while ld_n is low, and stays low otherwise.
- R10: Synchronous reset rst clears the shift register, sets all channels to 0x000 and holds proto_err low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low serial select |
| sclk | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial data in |
| ld_n | input | 1 | Active-low level-sensitive load |
| clr_n | input | 1 | Active-low clear of all channels |
| clsel | input | 1 | Clear value select: 1 midscale, 0 zero-scale |
| ch_code | output | 48 | Four 12-bit channel codes, channel 0 in the low bits |
| proto_err | output | 1 | One-cycle pulse for a shift during load |

## Verification
The assertions assume that every pin holds its level for several system clock cycles between changes, so that each synchronized change is seen exactly once and no edge is lost inside the synchronizer. The bench holds each pin phase for four system cycles and lets the pipeline settle before it samples any output. The assertions also assume that reset is applied from time zero. The bench starts in reset and changes clear and load only while the serial port is idle, except in the tests that deliberately exercise the overlap cases.

// File: rtl/qdac_pkg.sv
`timescale 1ns/1ps
package qdac_pkg;
    localparam int DATA_W_DEF = 12;
    localparam int ADDR_W_DEF = 2;
    localparam int FILL_W_DEF = 2;

    typedef enum logic [1:0] {
        CH_0 = 2'd0,
        CH_1 = 2'd1,
        CH_2 = 2'd2,
        CH_3 = 2'd3
    } chan_id_t;

    // Midscale code for a converter of width w: only the top bit set.
    function automatic logic [31:0] midscale(input int w);
        return 32'(1) << (w - 1);
    endfunction

    // Value forced by clear, chosen by the range-select level.
    function automatic logic [31:0] clear_code(input logic mid, input int w);
        return mid ? midscale(w) : 32'd0;
    endfunction
endpackage

// File: rtl/qdac_pin_sync.sv
`timescale 1ns/1ps
module qdac_pin_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/qdac_shift_port.sv
`timescale 1ns/1ps
module qdac_shift_port #(
    parameter int ADDR_W = qdac_pkg::ADDR_W_DEF,
    parameter int FILL_W = qdac_pkg::FILL_W_DEF,
    parameter int DATA_W = qdac_pkg::DATA_W_DEF,
    localparam int WORD_W = ADDR_W + FILL_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              shift_pulse,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    logic              eff_clk;
    logic              eff_q;
    logic [WORD_W-1:0] frame;

    // Select and serial clock merge into one shift clock.
    assign eff_clk     = sclk | cs_n;
    assign shift_pulse = eff_clk & ~eff_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            eff_q <= 1'b1;
            frame <= '0;
        end else begin
            eff_q <= eff_clk;
            if (shift_pulse) begin
                frame <= {frame[WORD_W-2:0], sdi};
            end
        end
    end

    assign addr = frame[WORD_W-1 -: ADDR_W];
    assign data = frame[DATA_W-1:0];
endmodule

// File: rtl/qdac_chan_bank.sv
`timescale 1ns/1ps
module qdac_chan_bank #(
    parameter int ADDR_W = qdac_pkg::ADDR_W_DEF,
    parameter int DATA_W = qdac_pkg::DATA_W_DEF,
    localparam int NUM_CH = 1 << ADDR_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           clr_n,
    input  logic                           clsel,
    input  logic                           ld_n,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              data,
    output logic [NUM_CH-1:0][DATA_W-1:0]  ch_code
);
    localparam logic [DATA_W-1:0] MID_CODE  = DATA_W'(qdac_pkg::clear_code(1'b1, DATA_W));
    localparam logic [DATA_W-1:0] ZERO_CODE = DATA_W'(qdac_pkg::clear_code(1'b0, DATA_W));

    logic [DATA_W-1:0] clr_val;
    assign clr_val = clsel ? MID_CODE : ZERO_CODE;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        logic hit;
        assign hit = !ld_n && (addr == ADDR_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                ch_code[i] <= '0;
            end else if (!clr_n) begin
                ch_code[i] <= clr_val;
            end else if (hit) begin
                ch_code[i] <= data;
            end
        end
    end
endmodule

// File: rtl/qdac_front.sv
`timescale 1ns/1ps
module qdac_front #(
    parameter int ADDR_W = qdac_pkg::ADDR_W_DEF,
    parameter int FILL_W = qdac_pkg::FILL_W_DEF,
    parameter int DATA_W = qdac_pkg::DATA_W_DEF,
    localparam int NUM_CH = 1 << ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cs_n,
    input  logic                          sclk,
    input  logic                          sdi,
    input  logic                          ld_n,
    input  logic                          clr_n,
    input  logic                          clsel,
    output logic [NUM_CH-1:0][DATA_W-1:0] ch_code,
    output logic                          proto_err
);
    // Synchronized pin vector: {cs_n, sclk, sdi, ld_n, clr_n, clsel}
    localparam int PIN_W = 6;
    localparam logic [PIN_W-1:0] PIN_IDLE = 6'b1_0_0_1_1_0;

    logic [PIN_W-1:0]  pins_s;
    logic              cs_n_s, sclk_s, sdi_s, ld_n_s, clr_n_s, clsel_s;
    logic              shift_pulse;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;

    qdac_pin_sync #(.W(PIN_W), .RST_VAL(PIN_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, sclk, sdi, ld_n, clr_n, clsel}),
        .q   (pins_s)
    );

    assign {cs_n_s, sclk_s, sdi_s, ld_n_s, clr_n_s, clsel_s} = pins_s;

    qdac_shift_port #(.ADDR_W(ADDR_W), .FILL_W(FILL_W), .DATA_W(DATA_W)) u_port (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n_s),
        .sclk        (sclk_s),
        .sdi         (sdi_s),
        .shift_pulse (shift_pulse),
        .addr        (addr),
        .data        (data)
    );

    qdac_chan_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .clr_n   (clr_n_s),
        .clsel   (clsel_s),
        .ld_n    (ld_n_s),
        .addr    (addr),
        .data    (data),
        .ch_code (ch_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            proto_err <= 1'b0;
        end else begin
            proto_err <= shift_pulse && !ld_n_s;
        end
    end
endmodule

// File: rtl/qdac_front_chk.sv
`timescale 1ns/1ps
module qdac_front_chk #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 12,
    localparam int NUM_CH = 1 << ADDR_W
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          shift_pulse,
    input logic                          sdi_s,
    input logic                          ld_n_s,
    input logic                          clr_n_s,
    input logic                          clsel_s,
    input logic [ADDR_W-1:0]             addr,
    input logic [DATA_W-1:0]             data,
    input logic [NUM_CH-1:0][DATA_W-1:0] ch_code,
    input logic                          proto_err
);
    localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

    a_r2_shift_takes_sdi: assert property (@(posedge clk) disable iff (rst)
        shift_pulse |=> data[0] == $past(sdi_s));

    a_r8_no_edge_hold: assert property (@(posedge clk) disable iff (rst)
        !shift_pulse |=> $stable({addr, data}));

    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        (ld_n_s && clr_n_s) |=> $stable(ch_code));

    a_r6_clear_mid: assert property (@(posedge clk) disable iff (rst)
        (!clr_n_s && clsel_s) |=> ch_code == {NUM_CH{MID}});

    a_r6_clear_zero: assert property (@(posedge clk) disable iff (rst)
        (!clr_n_s && !clsel_s) |=> ch_code == '0);

    a_r9_err_flag: assert property (@(posedge clk) disable iff (rst)
        (shift_pulse && !ld_n_s) |=> proto_err);

    a_r9_err_quiet: assert property (@(posedge clk) disable iff (rst)
        !(shift_pulse && !ld_n_s) |=> !proto_err);
endmodule

bind qdac_front qdac_front_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .shift_pulse (shift_pulse),
    .sdi_s       (sdi_s),
    .ld_n_s      (ld_n_s),
    .clr_n_s     (clr_n_s),
    .clsel_s     (clsel_s),
    .addr        (addr),
    .data        (data),
    .ch_code     (ch_code),
    .proto_err   (proto_err)
);

// File: tb/qdac_front_tb_top.sv
`timescale 1ns/1ps
module qdac_front_tb_top;
    localparam int P      = 4;
    localparam int SETTLE = 10;
    localparam logic [15:0] VEC [8] = '{
        16'h0123, 16'h4456, 16'h8789, 16'hCABC,
        16'h3FFF, 16'h7000, 16'hB801, 16'hE5A5
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, ld_n = 1'b1, clr_n = 1'b1, clsel = 1'b0;
    logic [3:0][11:0] ch_code;
    logic proto_err;

    int checks = 0;
    int errors = 0;
    int err_pulses = 0;
    logic [11:0] m [4];

    qdac_front dut_i (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .ld_n      (ld_n),
        .clr_n     (clr_n),
        .clsel     (clsel),
        .ch_code   (ch_code),
        .proto_err (proto_err)
    );

    always @(posedge clk) if (!rst && proto_err === 1'b1) err_pulses++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_ch(input string req, input int idx, input logic [11:0] exp);
        checks++;
        if (ch_code[idx] !== exp) begin
            errors++;
            $display("FAIL %s: ch%0d got %h expected %h", req, idx, ch_code[idx], exp);
        end
    endtask

    task automatic check_model(input string req);
        for (int i = 0; i < 4; i++) check_ch(req, i, m[i]);
    endtask

    task automatic check_int(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic send_word(input logic [15:0] w);
        sclk = 1'b0; tick(P);
        cs_n = 1'b0; tick(P);
        for (int i = 15; i >= 0; i--) begin
            sdi = w[i]; sclk = 1'b0; tick(P);
            sclk = 1'b1; tick(P);
        end
        cs_n = 1'b1; tick(P);
        sclk = 1'b0; tick(P);
    endtask

    task automatic strobe_ld();
        ld_n = 1'b0; tick(P);
        ld_n = 1'b1; tick(SETTLE);
    endtask

    task automatic do_reset();
        rst = 1'b1; tick(3);
        rst = 1'b0; tick(SETTLE);
        for (int i = 0; i < 4; i++) m[i] = 12'h000;
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(2);
        do_reset();
        // R10: reset state
        check_model("R10 reset channels");
        check_int("R10 reset proto_err", int'(proto_err), 0);

        // R1 / R2 / R4: table of frames, one load each
        foreach (VEC[k]) begin
            send_word(VEC[k]);
            strobe_ld();
            m[VEC[k][15:14]] = VEC[k][11:0];
            check_model("R1 R2 R4 frame routing");
        end

        // R5: transparent while load low, hold when high
        send_word(16'h9777);
        ld_n = 1'b0; tick(SETTLE);
        check_ch("R5 transparent", 2, 12'h777);
        ld_n = 1'b1; tick(P);
        m[2] = 12'h777;
        send_word(16'h9111);
        check_model("R5 hold without load");

        // R8: select high blocks sclk activity
        cs_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            sdi = i[0]; sclk = 1'b1; tick(P);
            sclk = 1'b0; tick(P);
        end
        strobe_ld();
        m[2] = 12'h111;
        check_model("R8 idle sclk ignored");

        // R3: select rising with sclk low adds one bit (sdi=1)
        sclk = 1'b0; tick(P);
        cs_n = 1'b0; tick(P);
        for (int i = 15; i >= 0; i--) begin
            sdi = 1'(16'h0ABC >> i); sclk = 1'b0; tick(P);
            sclk = 1'b1; tick(P);
        end
        sclk = 1'b0; sdi = 1'b1; tick(P);
        cs_n = 1'b1; tick(P);
        strobe_ld();
        m[0] = 12'h579;   // frame becomes 0x1579
        check_model("R3 false clock extra bit");

        // R6 / R7: clear to midscale, load ignored, reload pre-clear frame
        send_word(16'h5123);
        strobe_ld();
        m[1] = 12'h123;
        send_word(16'hA456);
        clsel = 1'b1; clr_n = 1'b0; tick(SETTLE);
        ld_n = 1'b0; tick(SETTLE);
        for (int i = 0; i < 4; i++) m[i] = 12'h800;
        check_model("R6 midscale with load low");
        ld_n = 1'b1; tick(SETTLE);
        clr_n = 1'b1; tick(SETTLE);
        check_model("R7 hold after clear");
        strobe_ld();
        m[2] = 12'h456;
        check_model("R7 reload pre-clear frame");
        clsel = 1'b0; clr_n = 1'b0; tick(SETTLE);
        for (int i = 0; i < 4; i++) m[i] = 12'h000;
        check_model("R6 zero-scale clear");
        clr_n = 1'b1; tick(SETTLE);

        // R9: no error so far, then shift during load
        check_int("R9 no spurious error", err_pulses, 0);
        ld_n = 1'b0; tick(P);
        cs_n = 1'b0; tick(P);
        sclk = 1'b1; tick(SETTLE);
        check_int("R9 error on shift during load", err_pulses, 1);
        ld_n = 1'b1; sclk = 1'b0; tick(P);
        cs_n = 1'b1; tick(SETTLE);

        // R10: reset clears the shift register as well
        send_word(16'h0ABC);
        strobe_ld();
        do_reset();
        check_model("R10 reset after data");
        strobe_ld();
        check_ch("R10 shift register cleared", 0, 12'h000);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule